// File: doc/BRIEF.md
# Tripled-Line Framebuffer Scanout for 640x480 VGA

This block drives a VGA monitor at 640x480, 60 Hz, straight from a 72 MHz system clock. It keeps no pixel clock of its own. All horizontal timing is counted in system clocks. A new pixel is shown every nine clocks, starting well after the sync pulse, so that the visible span lines up with the monitor's active window. Pixels come from an external byte-wide frame buffer through a synchronous read port with one cycle of latency. The three low bits of each byte drive a 3-bit RGB output.

The frame buffer is coarse. Each stored row is put on the screen for three scanlines in a row, so 160 stored rows fill 480 lines. Once the last row has been shown three times, the row and repeat counters clear and the read pointer goes back to the buffer base. RGB then stays dark until the active region of the next frame. A one-clock `frame_start` pulse marks the first active line, and the `in_frame` level covers the whole active region, so software can time its buffer updates.

Three state machines make up the block:
- **Horizontal phase machine.** States: `HS_SYNC`, then `HS_BACK`, then `HS_ACTIVE`, then `HS_FRONT`, then back to `HS_SYNC` at the wrap of the line counter. Each step is taken when the next clock count reaches the boundary of that phase.
- **Vertical phase machine.** States: `VS_SYNC`, then `VS_BACK`, then `VS_ACTIVE`, then `VS_TAIL`, then back to `VS_SYNC`. It steps only at line ends. `VS_ACTIVE` is left when the last row finishes its last repeat. If no tail lines remain, it goes straight to `VS_SYNC`.
- **Fetch machine.** States: `FT_IDLE`, then `FT_ISSUE`, then `FT_GAP`, then back to `FT_ISSUE`, and finally to `FT_IDLE`. It is armed three clocks before the first pixel on every active line. It issues one read per pixel period. It returns to `FT_IDLE` after the last column of the row.

Top module: `vga_tripler_scanout`

## Requirements
- R1: While reset is asserted, and right after it, `hsync_n` and `vsync_n` are low, while `rgb`, `in_frame`, `frame_start` and `fb_rd_en` are 0. Timing then starts at line clock 0 of line 0.
- R2: A line lasts H_TOTAL clocks (default 2288). `hsync_n` is low for line clocks 0 to HSYNC_LEN-1 (default 275) and high for the rest of the line.
- R3: A frame lasts V_TOTAL lines (default 525). `vsync_n` is low for lines 0 to VSYNC_LEN-1 (default 2), and it changes only at line clock 0.
- R4: `in_frame` is high exactly on lines V_ACT_START to V_ACT_START+3*ROWS-1. With the defaults these are lines 35 to 514.
- R5: `frame_start` is high for one clock only, at line clock 0 of line V_ACT_START, in every frame.
- R6: On lines where `in_frame` is high, `fb_rd_en` is high for one clock at line clocks H_ACT_START-2+j*PIX_CLKS, for j from 0 to ROW_STRIDE-1. It is low at every other time.
- R7: The read address for column j on active line n is BASE_ADDR + ((n-V_ACT_START)/3)*ROW_STRIDE + j. Each stored row is therefore read on three consecutive lines.
- R8: For line clocks H_ACT_START+j*PIX_CLKS to H_ACT_START+(j+1)*PIX_CLKS-1 on an active line, `rgb` equals bits 2:0 of the byte read for column j. Red is bit 0, green is bit 1 and blue is bit 2. Bits 7:3 of the read data have no effect, and neither does read data returned when no read was issued.
- R9: `rgb` is 0 before H_ACT_START and after the last pixel period of every line, and on every line outside the active region, including the tail after the last row.
- R10: After the last row's third line the read pointer returns to BASE_ADDR. The first read of every frame, including the frames after the first, is at BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (72 MHz in the target timing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_rd_en | output | 1 | Frame buffer read strobe, one clock per pixel |
| fb_rd_addr | output | ADDR_W | Frame buffer byte address |
| fb_rd_data | input | 8 | Byte returned one clock after `fb_rd_en` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 3 | Colour bits {blue, green, red} |
| frame_start | output | 1 | One-clock pulse at the start of the active region |
| in_frame | output | 1 | High throughout the active line region |

## Verification
The assertions assume that the read data port behaves as a synchronous memory: whatever comes back is consumed only in the clock after a strobe. They do not assume anything about the data values. They also assume that the timing parameters keep the sync, porch and pixel span inside one line, with H_ACT_START of at least 3, and keep the tripled rows inside one frame. The bench uses a reduced but legal parameter set, so that several whole frames fit in a short run. Its memory model returns a random byte on every clock with no strobe, and random upper bits on every read. This shows that only the strobed low three bits reach the screen. The buffer contents are re-randomised at the start of each frame. A reset is applied at a random point in the middle of a frame.

// File: rtl/vga_tri_pkg.sv
package vga_tri_pkg;

    typedef enum logic [1:0] {
        HS_SYNC,
        HS_BACK,
        HS_ACTIVE,
        HS_FRONT
    } hphase_t;

    typedef enum logic [1:0] {
        VS_SYNC,
        VS_BACK,
        VS_ACTIVE,
        VS_TAIL
    } vphase_t;

    typedef enum logic [1:0] {
        FT_IDLE,
        FT_ISSUE,
        FT_GAP
    } fetch_t;

endpackage

// File: rtl/vga_tri_hline.sv
module vga_tri_hline
    import vga_tri_pkg::*;
#(
    parameter int H_TOTAL     = 2288,
    parameter int HSYNC_LEN   = 275,
    parameter int H_ACT_START = 412,
    parameter int ACT_CLKS    = 1836,
    localparam int HW         = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output hphase_t       hph,
    output logic          line_start,
    output logic          line_end
);

    logic [HW-1:0] hcnt_q, hcnt_d;
    hphase_t       st_q, st_d;

    // next clock count within the line
    always_comb begin
        if (hcnt_q == HW'(H_TOTAL - 1)) hcnt_d = '0;
        else                            hcnt_d = hcnt_q + 1'b1;
    end

    // phase transitions, taken when the next count reaches a boundary
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_SYNC:   if (hcnt_d == HW'(HSYNC_LEN))              st_d = HS_BACK;
            HS_BACK:   if (hcnt_d == HW'(H_ACT_START))            st_d = HS_ACTIVE;
            HS_ACTIVE: if (hcnt_d == HW'(H_ACT_START + ACT_CLKS)) st_d = HS_FRONT;
            HS_FRONT:  if (hcnt_d == '0)                          st_d = HS_SYNC;
            default:                                              st_d = HS_SYNC;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= HS_SYNC;
            hcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            hcnt_q <= hcnt_d;
        end
    end

    // outputs
    always_comb begin
        hcnt       = hcnt_q;
        hph        = st_q;
        line_start = (hcnt_q == '0);
        line_end   = (hcnt_q == HW'(H_TOTAL - 1));
    end

endmodule

// File: rtl/vga_tri_vframe.sv
module vga_tri_vframe
    import vga_tri_pkg::*;
#(
    parameter int V_TOTAL     = 525,
    parameter int VSYNC_LEN   = 2,
    parameter int V_ACT_START = 35,
    parameter int ROWS        = 160,
    parameter int LINE_REPEAT = 3,
    parameter int ROW_STRIDE  = 204,
    parameter int ADDR_W      = 16,
    parameter int BASE_ADDR   = 0,
    localparam int VW         = $clog2(V_TOTAL),
    localparam int RW         = $clog2(ROWS + 1),
    localparam int PW         = $clog2(LINE_REPEAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    output vphase_t           vph,
    output logic [ADDR_W-1:0] row_base,
    output logic              first_line
);

    logic [VW-1:0]     vcnt_q, vcnt_d;
    logic [RW-1:0]     row_q;
    logic [PW-1:0]     rep_q;
    logic [ADDR_W-1:0] base_q;
    vphase_t           st_q, st_d;
    logic              last_rep, last_row;

    assign last_rep = (rep_q == PW'(LINE_REPEAT - 1));
    assign last_row = (row_q == RW'(ROWS - 1));

    always_comb begin
        vcnt_d = vcnt_q;
        if (line_end) begin
            if (vcnt_q == VW'(V_TOTAL - 1)) vcnt_d = '0;
            else                            vcnt_d = vcnt_q + 1'b1;
        end
    end

    // vertical phase transitions, only at line ends
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            VS_SYNC:   if (line_end && vcnt_d == VW'(VSYNC_LEN))   st_d = VS_BACK;
            VS_BACK:   if (line_end && vcnt_d == VW'(V_ACT_START)) st_d = VS_ACTIVE;
            VS_ACTIVE: if (line_end && last_row && last_rep)
                           st_d = (vcnt_d == '0) ? VS_SYNC : VS_TAIL;
            VS_TAIL:   if (line_end && vcnt_d == '0)               st_d = VS_SYNC;
            default:                                               st_d = VS_SYNC;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= VS_SYNC;
            vcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            vcnt_q <= vcnt_d;
        end
    end

    // row and repeat sequencing across active lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q  <= '0;
            row_q  <= '0;
            base_q <= ADDR_W'(BASE_ADDR);
        end else if (st_q == VS_ACTIVE && line_end) begin
            if (last_rep) begin
                rep_q <= '0;
                if (last_row) begin
                    row_q  <= '0;
                    base_q <= ADDR_W'(BASE_ADDR);
                end else begin
                    row_q  <= row_q + 1'b1;
                    base_q <= base_q + ADDR_W'(ROW_STRIDE);
                end
            end else begin
                rep_q <= rep_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        vph        = st_q;
        row_base   = base_q;
        first_line = (st_q == VS_ACTIVE) && (row_q == '0) && (rep_q == '0);
    end

endmodule

// File: rtl/vga_tri_fetch.sv
module vga_tri_fetch
    import vga_tri_pkg::*;
#(
    parameter int PIX_CLKS   = 9,
    parameter int ROW_STRIDE = 204,
    parameter int ADDR_W     = 16,
    localparam int CW        = $clog2(ROW_STRIDE + 1),
    localparam int PHW       = $clog2(PIX_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] row_base,
    input  logic [2:0]        rd_bits,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [2:0]        pix
);

    fetch_t         st_q, st_d;
    logic [CW-1:0]  col_q;
    logic [PHW-1:0] ph_q;
    logic           cap_q;
    logic [2:0]     pix_q;
    logic           last_col;

    assign last_col = (col_q == CW'(ROW_STRIDE - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FT_IDLE:  if (arm) st_d = FT_ISSUE;
            FT_ISSUE: begin
                if (last_col)           st_d = FT_IDLE;
                else if (PIX_CLKS == 1) st_d = FT_ISSUE;
                else                    st_d = FT_GAP;
            end
            FT_GAP:   if (int'(ph_q) == PIX_CLKS - 2) st_d = FT_ISSUE;
            default:  st_d = FT_IDLE;
        endcase
    end

    // state register with column and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FT_IDLE;
            col_q <= '0;
            ph_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == FT_ISSUE) col_q <= last_col ? '0 : col_q + 1'b1;
            if (st_q == FT_GAP && st_d == FT_GAP) ph_q <= ph_q + 1'b1;
            else                                  ph_q <= '0;
        end
    end

    // capture the returned byte one clock after the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            pix_q <= '0;
        end else begin
            cap_q <= (st_q == FT_ISSUE);
            if (cap_q) pix_q <= rd_bits;
        end
    end

    // outputs
    always_comb begin
        rd_en   = (st_q == FT_ISSUE);
        rd_addr = row_base + ADDR_W'(col_q);
        pix     = pix_q;
    end

endmodule

// File: rtl/vga_tripler_scanout.sv
module vga_tripler_scanout
    import vga_tri_pkg::*;
#(
    parameter int H_TOTAL     = 2288,
    parameter int HSYNC_LEN   = 275,
    parameter int H_ACT_START = 412,
    parameter int PIX_CLKS    = 9,
    parameter int V_TOTAL     = 525,
    parameter int VSYNC_LEN   = 2,
    parameter int V_ACT_START = 35,
    parameter int ROWS        = 160,
    parameter int LINE_REPEAT = 3,
    parameter int ROW_STRIDE  = 204,
    parameter int ADDR_W      = 16,
    parameter int BASE_ADDR   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_rd_addr,
    input  logic [7:0]        fb_rd_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic [2:0]        rgb,
    output logic              frame_start,
    output logic              in_frame
);

    localparam int HW       = $clog2(H_TOTAL);
    localparam int ACT_CLKS = PIX_CLKS * ROW_STRIDE;

    logic [HW-1:0]     hcnt;
    hphase_t           hph;
    vphase_t           vph;
    logic              line_start, line_end, first_line, arm;
    logic [ADDR_W-1:0] row_base;
    logic [2:0]        pix;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^fb_rd_data[7:3];

    vga_tri_hline #(
        .H_TOTAL    (H_TOTAL),
        .HSYNC_LEN  (HSYNC_LEN),
        .H_ACT_START(H_ACT_START),
        .ACT_CLKS   (ACT_CLKS)
    ) u_hline (
        .clk       (clk),
        .rst_n     (rst_n),
        .hcnt      (hcnt),
        .hph       (hph),
        .line_start(line_start),
        .line_end  (line_end)
    );

    vga_tri_vframe #(
        .V_TOTAL    (V_TOTAL),
        .VSYNC_LEN  (VSYNC_LEN),
        .V_ACT_START(V_ACT_START),
        .ROWS       (ROWS),
        .LINE_REPEAT(LINE_REPEAT),
        .ROW_STRIDE (ROW_STRIDE),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR)
    ) u_vframe (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .vph       (vph),
        .row_base  (row_base),
        .first_line(first_line)
    );

    // arm three clocks ahead so the first strobe lands two clocks before the pixel
    assign arm = (vph == VS_ACTIVE) && (hcnt == HW'(H_ACT_START - 3));

    vga_tri_fetch #(
        .PIX_CLKS  (PIX_CLKS),
        .ROW_STRIDE(ROW_STRIDE),
        .ADDR_W    (ADDR_W)
    ) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .row_base(row_base),
        .rd_bits (fb_rd_data[2:0]),
        .rd_en   (fb_rd_en),
        .rd_addr (fb_rd_addr),
        .pix     (pix)
    );

    // output decode from registered phase state
    always_comb begin
        hsync_n     = (hph != HS_SYNC);
        vsync_n     = (vph != VS_SYNC);
        in_frame    = (vph == VS_ACTIVE);
        frame_start = first_line && line_start;
        rgb         = (hph == HS_ACTIVE && vph == VS_ACTIVE) ? pix : 3'b000;
    end

endmodule

// File: rtl/vga_tripler_scanout_chk.sv
module vga_tripler_scanout_chk #(
    parameter int HSYNC_LEN = 275,
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic [2:0]        rgb,
    input logic              frame_start,
    input logic              in_frame,
    input logic              fb_rd_en,
    input logic              line_start,
    input logic [ADDR_W-1:0] row_base
);

    int hs_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hs_low <= 0;
        else if (!hsync_n) hs_low <= hs_low + 1;
        else              hs_low <= 0;
    end

    assert_hsync_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> (hs_low < HSYNC_LEN));

    assert_vsync_on_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsync_n) |-> line_start);

    assert_frame_rise_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> frame_start);

    assert_frame_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_fetch_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |-> in_frame);

    assert_blank_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> (rgb == 3'b000));

    assert_pointer_rewind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> (row_base == ADDR_W'(BASE_ADDR)));

endmodule

bind vga_tripler_scanout vga_tripler_scanout_chk #(
    .HSYNC_LEN(HSYNC_LEN),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync_n    (hsync_n),
    .vsync_n    (vsync_n),
    .rgb        (rgb),
    .frame_start(frame_start),
    .in_frame   (in_frame),
    .fb_rd_en   (fb_rd_en),
    .line_start (line_start),
    .row_base   (row_base)
);

// File: tb/vga_tripler_scanout_bench.sv
module vga_tripler_scanout_bench;

    localparam int HT    = 40;
    localparam int HS    = 5;
    localparam int HA    = 10;
    localparam int PIX   = 3;
    localparam int VT    = 20;
    localparam int VS    = 2;
    localparam int VA    = 4;
    localparam int ROWS  = 3;
    localparam int REP   = 3;
    localparam int STR   = 8;
    localparam int AW    = 16;
    localparam int BASE  = 0;
    localparam int DEPTH = ROWS * STR;
    localparam int FRAME = HT * VT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fb_rd_en;
    logic [AW-1:0] fb_rd_addr;
    logic [7:0]    fb_rd_data = 8'h00;
    logic          hsync_n, vsync_n, frame_start, in_frame;
    logic [2:0]    rgb;

    always #5 clk = ~clk;

    vga_tripler_scanout #(
        .H_TOTAL(HT), .HSYNC_LEN(HS), .H_ACT_START(HA), .PIX_CLKS(PIX),
        .V_TOTAL(VT), .VSYNC_LEN(VS), .V_ACT_START(VA), .ROWS(ROWS),
        .LINE_REPEAT(REP), .ROW_STRIDE(STR), .ADDR_W(AW), .BASE_ADDR(BASE)
    ) u_vga_tripler_scanout (
        .clk(clk), .rst_n(rst_n), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
        .fb_rd_data(fb_rd_data), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .rgb(rgb), .frame_start(frame_start), .in_frame(in_frame)
    );

    logic [7:0] mem [DEPTH];
    int  tests = 0, fails = 0;
    int  pos = 0, h = 0, v = 0;
    bit  done = 1'b0;

    // synchronous read model; garbage on every clock without a strobe
    always @(posedge clk) begin
        if (fb_rd_en) fb_rd_data <= (int'(fb_rd_addr) < DEPTH) ? mem[fb_rd_addr] : 8'hFF;
        else          fb_rd_data <= 8'($urandom);
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, h, v);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
    endtask

    function automatic bit act_line(input int vv);
        return (vv >= VA) && (vv < VA + REP * ROWS);
    endfunction

    task automatic check_reset();
        chk("R1 hsync_n", int'(hsync_n), 0);
        chk("R1 vsync_n", int'(vsync_n), 0);
        chk("R1 rgb", int'(rgb), 0);
        chk("R1 in_frame", int'(in_frame), 0);
        chk("R1 frame_start", int'(frame_start), 0);
        chk("R1 fb_rd_en", int'(fb_rd_en), 0);
    endtask

    task automatic check_pos();
        int fh, ph, row;
        bit av, rd_exp, win;
        h   = pos % HT;
        v   = (pos / HT) % VT;
        av  = act_line(v);
        row = (v - VA) / REP;
        fh  = h - (HA - 2);
        ph  = h - HA;
        rd_exp = av && fh >= 0 && (fh % PIX) == 0 && (fh / PIX) < STR;
        win    = av && ph >= 0 && ph < STR * PIX;
        chk("R2 hsync_n", int'(hsync_n), (h < HS) ? 0 : 1);
        chk("R3 vsync_n", int'(vsync_n), (v < VS) ? 0 : 1);
        chk("R4 in_frame", int'(in_frame), int'(av));
        chk("R5 frame_start", int'(frame_start), (v == VA && h == 0) ? 1 : 0);
        chk("R6 fb_rd_en", int'(fb_rd_en), int'(rd_exp));
        if (rd_exp && fb_rd_en) begin
            if (v == VA && fh == 0) chk("R10 first address", int'(fb_rd_addr), BASE);
            else chk("R7 address", int'(fb_rd_addr), BASE + row * STR + fh / PIX);
        end
        if (win) chk("R8 rgb", int'(rgb), int'(mem[row * STR + ph / PIX] & 8'h07));
        else     chk("R9 rgb blank", int'(rgb), 0);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pos++;
            if (pos % FRAME == 0) fill_mem();
            check_pos();
        end
    endtask

    initial begin
        int unsigned seed_init;
        int k;
        seed_init = $urandom(32'h1F3A);
        fill_mem();
        repeat (4) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        pos = 0;
        run_cycles(2 * FRAME);
        // directed corner: reset in the middle of a frame
        k = int'($urandom_range(60, 700));
        run_cycles(k);
        rst_n = 1'b0;
        #1;
        check_reset();
        repeat (2) @(negedge clk);
        check_reset();
        fill_mem();
        rst_n = 1'b1;
        pos = 0;
        check_pos();
        run_cycles(2 * FRAME + 5);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule